// File: doc/BRIEF.md
# Transactional Cache With Overflow Spill Store

This block is a small two-way set-associative data cache for one core. It lets a transaction touch more lines than the cache holds. The core opens a transaction with a begin pulse. Every line the core reads or writes while the transaction is open is marked speculative, and its current value stays in the cache. When a speculative line has to leave its set, it moves into a small fully associative spill store, and the set is flagged as having spilled. A later miss in a flagged set looks in the spill store first. If the line is there, it trades places with the victim line, much as a victim cache does. A miss that finds nothing in the store becomes an ordinary fill from backing memory.

A commit pulse makes the transaction permanent. The spill store drains to backing memory, and all speculative marks and spill flags are cleared. While the drain is running, external interventions are refused. An abort pulse drops every speculative line and empties the spill store. Backing memory is never written with speculative data, so it still holds the values from before the transaction.

Outside a transaction the block is a plain write-back cache, and dirty victims go straight to memory. If a speculative victim has to spill but the store is full, the request stalls and a signal tells the core to abort.

Top module: `txn_spill_cache`

## Requirements
- R1: After reset every line is invalid, the spill store is empty, no transaction is open, and resp_valid, mem_req, ovf_full and snoop_nack are low.
- R2: A read miss fills the line from backing memory. A hit returns the latest value written. The victim is an invalid way if one exists, otherwise the least recently used way of the set (one bit per set, updated on every completed access).
- R3: A dirty victim that is not speculative is written to backing memory before it is replaced. Such a victim never enters the spill store.
- R4: Any access while a transaction is open marks the line speculative. If that line is dirty and not yet speculative, its old value is first written to backing memory.
- R5: Evicting a speculative line copies its address and data into a free spill slot and sets the set's spill flag. Nothing goes to backing memory.
- R6: A miss in a flagged set searches the spill store. A match swaps the stored line with the victim, and the access then completes with the stored data. Without a match, the miss is handled as an ordinary fill.
- R7: When a speculative victim must spill and every slot is occupied, ovf_full stays high and the request is not completed for as long as the request is held.
- R8: Abort invalidates every speculative line, empties the spill store and clears all speculative marks and spill flags. Later reads return the values from before the transaction, and backing memory keeps them.
- R9: Commit writes every spill-store entry to backing memory and clears the marks and flags. Lines that were speculative stay cached as dirty lines and are written back when they are later evicted.
- R10: snoop_nack equals snoop_valid while the commit drain still has entries to write, and is low at all other times.
- R11: Each completed access gives a one-cycle resp_valid pulse. resp_rdata carries the read value, or zero for a write. The core holds a request stable until that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core access request, held until resp_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address (low SW bits select the set) |
| req_wdata | input | DW | Write data |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | DW | Read data (zero for writes) |
| tx_begin | input | 1 | Opens a transaction (idle only) |
| tx_commit | input | 1 | Commits the open transaction |
| tx_abort | input | 1 | Aborts the open transaction |
| ovf_full | output | 1 | A spill is needed but the store is full; the core should abort |
| snoop_valid | input | 1 | External intervention present |
| snoop_nack | output | 1 | Intervention refused during the commit drain |
| mem_req | output | 1 | Backing-memory request, held until mem_ack |
| mem_we | output | 1 | Backing-memory write enable |
| mem_addr | output | AW | Backing-memory word address |
| mem_wdata | output | DW | Backing-memory write data |
| mem_rdata | input | DW | Backing-memory read data, valid with mem_ack |
| mem_ack | input | 1 | Backing-memory completion |

## Verification
The bench steers three conflicting lines into one set so that a spilled line is swapped back while another speculative line goes out in its place. A design that dropped the outgoing line, or that returned memory data instead of the stored value, would give a wrong read. The bench first leaves a line dirty outside a transaction and then writes it speculatively. Backing memory must still hold the old committed value after the abort; a design that skipped that first write-back would lose committed data. Further cases are a miss in a flagged set that must fall through to memory, ten speculative writes into one set that fill the store and must stall the eleventh, and refusal of interventions only while the drain still has entries. After a commit, a line that was speculative must reach memory when it is evicted later.

// File: rtl/txn_spill_cache.sv
module txn_spill_cache #(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int SETS  = 4,
  parameter int OVF_N = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          resp_valid,
  output logic [DW-1:0] resp_rdata,
  input  logic          tx_begin,
  input  logic          tx_commit,
  input  logic          tx_abort,
  output logic          ovf_full,
  input  logic          snoop_valid,
  output logic          snoop_nack,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ack
);
  localparam int SW = $clog2(SETS);
  localparam int TW = AW - SW;
  localparam int OW = $clog2(OVF_N);

  typedef enum logic [2:0] {S_IDLE, S_WB, S_FILL, S_CMT, S_RESP} state_t;
  state_t state;

  logic [TW-1:0] tags  [SETS][2];
  logic [DW-1:0] lines [SETS][2];
  logic [1:0]    vbit [SETS];
  logic [1:0]    tbit [SETS];
  logic [1:0]    dbit [SETS];
  logic [SETS-1:0] lru, obit;
  logic tx_act;

  logic [OVF_N-1:0] ovf_vld;
  logic [AW-1:0]    ovf_addr [OVF_N];
  logic [DW-1:0]    ovf_data [OVF_N];

  logic [AW-1:0] wb_addr;
  logic [DW-1:0] wb_data;
  logic [SW-1:0] wb_set;
  logic          wb_way, fill_way;

  wire [SW-1:0] set = req_addr[SW-1:0];
  wire [TW-1:0] tg  = req_addr[AW-1:SW];
  wire hit0 = vbit[set][0] && tags[set][0] == tg;
  wire hit1 = vbit[set][1] && tags[set][1] == tg;
  wire hit  = hit0 | hit1;
  wire hway = hit1;
  wire vw   = !vbit[set][0] ? 1'b0 : !vbit[set][1] ? 1'b1 : lru[set];
  wire v_valid = vbit[set][vw];
  wire v_t     = tbit[set][vw];
  wire v_dirty = dbit[set][vw];
  wire clean_first = tx_act && dbit[set][hway] && !tbit[set][hway];
  wire any_ovf  = |ovf_vld;
  wire has_free = !(&ovf_vld);

  logic found;
  logic [OW-1:0] fidx, free_idx, cidx;
  always_comb begin
    found = 1'b0; fidx = '0; free_idx = '0; cidx = '0;
    for (int i = OVF_N - 1; i >= 0; i--) begin
      if (ovf_vld[i] && ovf_addr[i] == req_addr) begin found = obit[set]; fidx = OW'(i); end
      if (!ovf_vld[i]) free_idx = OW'(i);
      if (ovf_vld[i]) cidx = OW'(i);
    end
  end

  assign resp_valid = state == S_RESP;
  assign mem_req    = state == S_WB || state == S_FILL || (state == S_CMT && any_ovf);
  assign mem_we     = state != S_FILL;
  assign mem_addr   = state == S_FILL ? req_addr : state == S_WB ? wb_addr : ovf_addr[cidx];
  assign mem_wdata  = state == S_WB ? wb_data : ovf_data[cidx];
  assign snoop_nack = snoop_valid && state == S_CMT && any_ovf;
  assign ovf_full   = state == S_IDLE && req_valid && !tx_abort && !tx_commit && !tx_begin &&
                      !hit && !found && v_valid && v_t && !has_free;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; tx_act <= 1'b0; lru <= '0; obit <= '0; ovf_vld <= '0;
      resp_rdata <= '0; wb_addr <= '0; wb_data <= '0; wb_set <= '0; wb_way <= 1'b0; fill_way <= 1'b0;
      for (int s = 0; s < SETS; s++) begin
        vbit[s] <= '0; tbit[s] <= '0; dbit[s] <= '0;
        for (int w = 0; w < 2; w++) begin tags[s][w] <= '0; lines[s][w] <= '0; end
      end
      for (int i = 0; i < OVF_N; i++) begin ovf_addr[i] <= '0; ovf_data[i] <= '0; end
    end else begin
      case (state)
        S_IDLE: begin
          if (tx_abort) begin
            for (int s = 0; s < SETS; s++) begin vbit[s] <= vbit[s] & ~tbit[s]; tbit[s] <= '0; end
            obit <= '0; ovf_vld <= '0; tx_act <= 1'b0;
          end else if (tx_commit) begin
            for (int s = 0; s < SETS; s++) tbit[s] <= '0;
            obit <= '0; tx_act <= 1'b0;
            if (any_ovf) state <= S_CMT;
          end else if (tx_begin) begin
            tx_act <= 1'b1;
          end else if (req_valid) begin
            if (hit && clean_first) begin
              wb_addr <= req_addr; wb_data <= lines[set][hway]; wb_set <= set; wb_way <= hway;
              state <= S_WB;
            end else if (hit) begin
              lru[set] <= ~hway;
              tbit[set][hway] <= tbit[set][hway] | tx_act;
              if (req_write) begin lines[set][hway] <= req_wdata; dbit[set][hway] <= 1'b1; end
              resp_rdata <= req_write ? '0 : lines[set][hway];
              state <= S_RESP;
            end else if (v_valid && !v_t && v_dirty) begin
              wb_addr <= {tags[set][vw], set}; wb_data <= lines[set][vw]; wb_set <= set; wb_way <= vw;
              state <= S_WB;
            end else if (found) begin
              if (v_valid && v_t) begin
                ovf_addr[fidx] <= {tags[set][vw], set}; ovf_data[fidx] <= lines[set][vw];
              end else ovf_vld[fidx] <= 1'b0;
              vbit[set][vw] <= 1'b1; tbit[set][vw] <= 1'b1; dbit[set][vw] <= 1'b1;
              tags[set][vw] <= tg; lines[set][vw] <= ovf_data[fidx];
            end else if (v_valid && v_t) begin
              if (has_free) begin
                ovf_vld[free_idx] <= 1'b1;
                ovf_addr[free_idx] <= {tags[set][vw], set}; ovf_data[free_idx] <= lines[set][vw];
                obit[set] <= 1'b1;
                vbit[set][vw] <= 1'b0; tbit[set][vw] <= 1'b0; dbit[set][vw] <= 1'b0;
              end
            end else begin
              fill_way <= vw; state <= S_FILL;
            end
          end
        end
        S_WB: if (mem_ack) begin dbit[wb_set][wb_way] <= 1'b0; state <= S_IDLE; end
        S_FILL: if (mem_ack) begin
          vbit[set][fill_way] <= 1'b1; tbit[set][fill_way] <= 1'b0; dbit[set][fill_way] <= 1'b0;
          tags[set][fill_way] <= tg; lines[set][fill_way] <= mem_rdata;
          state <= S_IDLE;
        end
        S_CMT: begin
          if (!any_ovf) state <= S_IDLE;
          else if (mem_ack) ovf_vld[cidx] <= 1'b0;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R10
  nack_drain_chk: assert property (@(posedge clk) disable iff (!rst_n) snoop_nack |-> (mem_req && mem_we));
  // R7
  full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n) ovf_full |=> !resp_valid);
  // R11
  resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) resp_valid |=> !resp_valid);
  // R8
  abort_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && tx_abort) |=> (ovf_vld == '0 && obit == '0 && !tx_act));
  // R5
  spill_in_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(ovf_vld) > $countones($past(ovf_vld))) |-> tx_act);
  // R2
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !mem_we) |=> ($stable(mem_addr) && mem_req));
endmodule

// File: tb/txn_spill_cache_tb.sv
`timescale 1ns/1ps
module txn_spill_cache_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, tx_begin = 0, tx_commit = 0, tx_abort = 0, snoop_valid = 0;
  logic [7:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic resp_valid, ovf_full, snoop_nack, mem_req, mem_we, mem_ack;
  logic [15:0] resp_rdata, mem_wdata, mem_rdata;
  logic [7:0] mem_addr;

  always #4 clk = ~clk;

  txn_spill_cache u_dut (.clk, .rst_n, .req_valid, .req_write, .req_addr, .req_wdata,
    .resp_valid, .resp_rdata, .tx_begin, .tx_commit, .tx_abort, .ovf_full, .snoop_valid,
    .snoop_nack, .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_rdata, .mem_ack);

  logic [15:0] bmem [256];
  int rd_cnt;
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 0; mem_rdata <= '0; rd_cnt <= 0;
      for (int a = 0; a < 256; a++) bmem[a] <= 16'h5000 + 16'(a);
    end else if (mem_req && !mem_ack) begin
      mem_ack <= 1;
      if (mem_we) bmem[mem_addr] <= mem_wdata;
      else begin mem_rdata <= bmem[mem_addr]; rd_cnt <= rd_cnt + 1; end
    end else mem_ack <= 0;
  end

  int total = 0, bad = 0;
  bit done = 0;
  logic [15:0] arch [256];
  logic [15:0] spec [256];
  bit specv [256];
  bit intx = 0;
  bit rd_q[$];
  logic [15:0] exp_q[$];
  string tag_q[$];

  function automatic logic [15:0] gv(input logic [7:0] a);
    return (intx && specv[a]) ? spec[a] : arch[a];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s actual=%h expected=%h", tag, act, exp); end
  endtask

  always @(negedge clk) if (resp_valid) begin
    if (exp_q.size() == 0) chk(0, "R11 unexpected response", 16'h0, 16'h0);
    else begin
      automatic bit rd = rd_q.pop_front();
      automatic logic [15:0] e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      if (rd) chk(resp_rdata == e, t, resp_rdata, e);
    end
  end

  task automatic access(input bit we, input logic [7:0] a, input logic [15:0] d, input string tag);
    @(negedge clk);
    req_valid = 1; req_write = we; req_addr = a; req_wdata = d;
    rd_q.push_back(!we); exp_q.push_back(gv(a)); tag_q.push_back(tag);
    if (we) begin if (intx) begin spec[a] = d; specv[a] = 1; end else arch[a] = d; end
    do @(negedge clk); while (!resp_valid);
    req_valid = 0;
  endtask

  task automatic ctl(input int which);
    @(negedge clk);
    if (which == 0) begin tx_begin = 1; intx = 1; end
    else if (which == 1) begin
      tx_commit = 1; intx = 0;
      for (int a = 0; a < 256; a++) if (specv[a]) begin arch[a] = spec[a]; specv[a] = 0; end
    end else begin
      tx_abort = 1; intx = 0;
      for (int a = 0; a < 256; a++) specv[a] = 0;
    end
    @(negedge clk);
    tx_begin = 0; tx_commit = 0; tx_abort = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++; $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int c0;
    for (int a = 0; a < 256; a++) begin arch[a] = 16'h5000 + 16'(a); specv[a] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!resp_valid && !mem_req && !ovf_full && !snoop_nack, "R1 reset outputs",
        {12'h0, resp_valid, mem_req, ovf_full, snoop_nack}, 16'h0);

    // R2 fill, hit, LRU
    access(0, 8'h03, 0, "R2 fill 03");
    access(0, 8'h07, 0, "R2 fill 07");
    c0 = rd_cnt;
    access(0, 8'h03, 0, "R2 hit 03");
    chk(rd_cnt == c0, "R2 hit no memory read", 16'(rd_cnt - c0), 16'h0);
    access(0, 8'h0B, 0, "R2 fill 0B");
    c0 = rd_cnt;
    access(0, 8'h03, 0, "R2 MRU kept");
    chk(rd_cnt == c0, "R2 MRU line kept", 16'(rd_cnt - c0), 16'h0);
    access(0, 8'h07, 0, "R2 LRU evicted");
    chk(rd_cnt == c0 + 1, "R2 LRU line evicted", 16'(rd_cnt - c0), 16'h1);
    @(negedge clk);
    chk(!resp_valid, "R11 single pulse", {15'h0, resp_valid}, 16'h0);

    // R3 dirty non-speculative victim written back
    access(1, 8'h13, 16'h1111, "R3 write 13");
    access(0, 8'h17, 0, "R3 read 17");
    access(0, 8'h1B, 0, "R3 read 1B");
    chk(bmem[8'h13] == 16'h1111, "R3 dirty writeback", bmem[8'h13], 16'h1111);
    access(0, 8'h13, 0, "R3 reread 13");

    // R5 R6 spill and swap in set 0, then R9 R10 commit
    ctl(0);
    access(1, 8'h04, 16'hA1A1, "R4 tx write 04");
    access(1, 8'h08, 16'hB2B2, "R4 tx write 08");
    access(1, 8'h0C, 16'hC3C3, "R5 tx write 0C spills 04");
    chk(bmem[8'h04] == 16'h5004, "R5 spill not in memory", bmem[8'h04], 16'h5004);
    access(0, 8'h04, 0, "R6 swap back 04");
    access(0, 8'h08, 0, "R6 swap back 08");
    access(0, 8'h10, 0, "R6 not found falls to fill");
    snoop_valid = 1;
    @(negedge clk);
    chk(!snoop_nack, "R10 no nack before commit", {15'h0, snoop_nack}, 16'h0);
    ctl(1);
    chk(snoop_nack, "R10 nack during drain", {15'h0, snoop_nack}, 16'h1);
    repeat (40) @(negedge clk);
    chk(!snoop_nack, "R10 nack released", {15'h0, snoop_nack}, 16'h0);
    snoop_valid = 0;
    chk(bmem[8'h0C] == 16'hC3C3, "R9 drained 0C", bmem[8'h0C], 16'hC3C3);
    chk(bmem[8'h04] == 16'hA1A1, "R9 drained 04", bmem[8'h04], 16'hA1A1);
    chk(bmem[8'h08] == 16'h5008, "R9 cached line not drained", bmem[8'h08], 16'h5008);
    access(0, 8'h14, 0, "R9 read 14");
    chk(bmem[8'h08] == 16'hB2B2, "R9 committed line written on eviction", bmem[8'h08], 16'hB2B2);
    access(0, 8'h08, 0, "R9 reread 08");

    // R4 clean-before-speculate, R8 abort in set 1
    access(1, 8'h01, 16'hD00D, "R4 plain write 01");
    ctl(0);
    access(1, 8'h01, 16'hE00E, "R4 tx write 01");
    chk(bmem[8'h01] == 16'hD00D, "R4 old value written first", bmem[8'h01], 16'hD00D);
    access(0, 8'h05, 0, "R4 tx read 05");
    access(1, 8'h09, 16'hF00F, "R5 tx write 09");
    access(0, 8'h01, 0, "R6 tx swap 01");
    ctl(2);
    access(0, 8'h01, 0, "R8 abort restores 01");
    access(0, 8'h09, 0, "R8 abort restores 09");
    access(0, 8'h05, 0, "R8 abort restores 05");
    chk(bmem[8'h09] == 16'h5009, "R8 memory untouched", bmem[8'h09], 16'h5009);

    // R7 full spill store
    ctl(0);
    for (int k = 0; k < 10; k++) access(1, 8'(8'h02 + 4 * k), 16'(16'h7000 + k), "R7 fill store");
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 8'h2A; req_wdata = 16'h7777;
    repeat (4) begin
      @(negedge clk);
      chk(ovf_full, "R7 full flagged", {15'h0, ovf_full}, 16'h1);
      chk(!resp_valid, "R7 request held", {15'h0, resp_valid}, 16'h0);
    end
    req_valid = 0;
    ctl(2);
    chk(!ovf_full, "R7 full cleared", {15'h0, ovf_full}, 16'h0);
    access(0, 8'h02, 0, "R8 abort restores 02");
    access(0, 8'h26, 0, "R8 abort restores 26");
    chk(bmem[8'h06] == 16'h5006, "R8 spilled data discarded", bmem[8'h06], 16'h5006);

    repeat (4) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule